// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is the timing heart of a system watchdog. Once enabled it loads a down-counter from a first preload and counts reference ticks. When that first window runs out it can raise an early-warning event (a normal interrupt or a system-management interrupt, chosen by a two-bit type field). It then reloads from a second preload and counts a second window. If the second window also runs out, the core can raise a one-cycle reset request and record that fact in a sticky flag. Software keeps the system alive by pulsing a keepalive input, which throws the count back to the start of the first window.

Each preload is scaled by one of two shift amounts, a long one for a slow time base and a short one for a fast time base. The counter steps once per cycle in which the reference tick input is high. In free-running mode the core goes back to the first window after the second one expires. Otherwise it parks in the second stage until a fresh enable edge or a keepalive arrives. Register access, unlock protection and the system reset itself belong to the surrounding logic.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the stage output reads 0 (first window), and the interrupt, system-management, reset-request and flag outputs are all low.
- R2: A window loaded from preload P lasts max(P << SLOW_SHIFT, 1) ticks when fast_scale_i is 0 and max(P << FAST_SHIFT, 1) ticks when it is 1. A preload of zero expires on the first tick.
- R3: The counter advances only in cycles where tick_i is high. A cycle without a tick leaves the remaining count unchanged.
- R4: A rising edge of en_i starts the first window from preload_one_i with stage_o = 0. While en_i is low the counter is frozen and no event, request or stage change occurs.
- R5: A keepalive pulse while en_i is high restarts the first window from preload_one_i and forces stage_o to 0. While en_i is low a keepalive has no effect.
- R6: When the first window expires, stage_o becomes 1 and the second window starts from preload_two_i. The event depends on evt_type_i: type 0 pulses irq_o, type 2 pulses smi_o, and types 1 and 3 pulse neither.
- R7: When the second window expires with reboot_en_i high, rst_req_o pulses and prev_reboot_o is set in the same cycle. With reboot_en_i low, neither changes.
- R8: When the second window expires with free_run_i high, stage_o returns to 0 and the first window restarts. Otherwise stage_o stays 1 and the core stays silent until an enable edge or a keepalive.
- R9: irq_o, smi_o and rst_req_o are single-cycle pulses, and irq_o and smi_o are never high together.
- R10: prev_reboot_o stays set until a cycle with flag_clr_i high. A new setting in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick; one count step per high cycle |
| en_i | input | 1 | Watchdog enable; a rising edge starts the first window |
| free_run_i | input | 1 | Restart the first window after the second window expires |
| reboot_en_i | input | 1 | Allow a reset request on second-window expiry |
| fast_scale_i | input | 1 | 1 selects the short preload shift, 0 the long one |
| evt_type_i | input | 2 | First-window event: 0 interrupt, 2 system-management, 1/3 none |
| kick_i | input | 1 | Keepalive pulse |
| preload_one_i | input | PRE_W | First-window preload |
| preload_two_i | input | PRE_W | Second-window preload |
| flag_clr_i | input | 1 | Clears the previous-reboot flag |
| irq_o | output | 1 | Interrupt event pulse |
| smi_o | output | 1 | System-management event pulse |
| rst_req_o | output | 1 | Reset request pulse |
| prev_reboot_o | output | 1 | Sticky flag: a watchdog reset was requested |
| stage_o | output | 1 | Current window: 0 first, 1 second |

## Verification
Every cycle, the assertions check the pulse shape and mutual exclusion of the events. They also check that events occur only on entry to the second window, that the core is quiet while disabled or parked, that a keepalive forces the first window, that a request is always paired with a set flag, and that the counter never wraps and holds between ticks. The exact window lengths can only be shown by the bench's scenarios: the shift-scaled durations for every small preload, the mapping of each type code to its event, the free-run restart, the gated-tick timing and the set-over-clear rule. The bench sweeps preloads, scales, types and mode bits and computes each duration by arithmetic.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    STG_ONE = 1'b0,
    STG_TWO = 1'b1
  } stage_e;

  localparam logic [1:0] EVT_CODE_IRQ = 2'd0;
  localparam logic [1:0] EVT_CODE_SMI = 2'd2;

  typedef struct packed {
    logic irq;
    logic smi;
  } evt_sel_t;

  // Map the two-bit event type to the line it drives at first-window expiry.
  function automatic evt_sel_t decode_evt(input logic [1:0] code);
    evt_sel_t r;
    r.irq = (code == EVT_CODE_IRQ);
    r.smi = (code == EVT_CODE_SMI);
    return r;
  endfunction

endpackage

// File: rtl/wdog_edge.sv
module wdog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rise_o
);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  assign rise_o = en_i & ~en_q;

  // R4: an enable edge is reported for one cycle only
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int PRE_W      = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_one_i,
  input  logic [PRE_W-1:0] pre_two_i,
  input  logic             fast_i,
  input  logic             load_i,
  input  logic             sel_two_i,
  input  logic             clear_i,
  input  logic             dec_i,
  output logic             last_o
);

  localparam int MAX_SHIFT = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
  localparam int CNT_W     = PRE_W + MAX_SHIFT;

  // Scale a preload into reference ticks for the selected time base.
  function automatic logic [CNT_W-1:0] scale_preload(input logic [PRE_W-1:0] pre,
                                                     input logic fast);
    logic [CNT_W-1:0] wide;
    wide = CNT_W'(pre);
    return fast ? (wide << FAST_SHIFT) : (wide << SLOW_SHIFT);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = scale_preload(sel_two_i ? pre_two_i : pre_one_i, fast_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val;
    else if (dec_i)   cnt_q <= cnt_q - 1'b1;
  end

  // A count of one or zero means the next tick ends the window.
  assign last_o = (cnt_q <= CNT_W'(1));

  // R3: without load, clear or step the remaining count is held
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i && !dec_i) |=> $stable(cnt_q));

  // R2: the sequencer never steps an exhausted count
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0));

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic       kick_i,
  input  logic       tick_i,
  input  logic       last_i,
  input  logic       free_run_i,
  input  logic       reboot_en_i,
  input  logic [1:0] evt_type_i,
  output logic       load_o,
  output logic       sel_two_o,
  output logic       clear_o,
  output logic       dec_o,
  output logic       flag_set_o,
  output logic       irq_o,
  output logic       smi_o,
  output logic       rst_req_o,
  output stage_e     stage_o
);

  stage_e   stage_q;
  logic     run_q;
  logic     irq_q, smi_q, req_q;
  logic     restart;
  logic     expire;
  logic     exp_one;
  logic     exp_two;
  logic     park;
  evt_sel_t evt;

  assign evt     = decode_evt(evt_type_i);
  assign restart = en_i & (rise_i | kick_i);
  assign expire  = run_q & en_i & tick_i & last_i & ~restart;
  assign exp_one = expire & (stage_q == STG_ONE);
  assign exp_two = expire & (stage_q == STG_TWO);
  assign park    = exp_two & ~free_run_i;

  // Counter control
  assign load_o     = restart | exp_one | (exp_two & free_run_i);
  assign sel_two_o  = exp_one;
  assign clear_o    = ~en_i | park;
  assign dec_o      = run_q & en_i & tick_i & ~restart & ~expire;
  assign flag_set_o = exp_two & reboot_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      stage_q <= STG_ONE;
    end else if (!en_i) begin
      run_q   <= 1'b0;
    end else if (restart) begin
      run_q   <= 1'b1;
      stage_q <= STG_ONE;
    end else if (exp_one) begin
      stage_q <= STG_TWO;
    end else if (exp_two) begin
      run_q   <= free_run_i;
      stage_q <= free_run_i ? STG_ONE : STG_TWO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      smi_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      irq_q <= exp_one & evt.irq;
      smi_q <= exp_one & evt.smi;
      req_q <= exp_two & reboot_en_i;
    end
  end

  assign irq_o     = irq_q;
  assign smi_o     = smi_q;
  assign rst_req_o = req_q;
  assign stage_o   = stage_q;

  // R9: single-cycle pulses
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r9_smi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |=> !smi_o);
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  a_r9_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && smi_o));

  // R6: an early-warning event coincides with entry into the second window
  a_r6_evt_in_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || smi_o) |-> (stage_o == STG_TWO));

  // R4: a disabled core produces nothing in the following cycle
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!irq_o && !smi_o && !rst_req_o && $stable(stage_o)));

  // R5: a keepalive while enabled forces the first window
  a_r5_kick_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && kick_i) |=> (stage_o == STG_ONE && !irq_o && !smi_o && !rst_req_o));

  // R8: a parked core stays silent until restarted
  a_r8_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart) |=> (!irq_o && !smi_o && !rst_req_o && $stable(stage_o)));

endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10: held without a clear, set wins against a clear
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int PRE_W      = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             free_run_i,
  input  logic             reboot_en_i,
  input  logic             fast_scale_i,
  input  logic [1:0]       evt_type_i,
  input  logic             kick_i,
  input  logic [PRE_W-1:0] preload_one_i,
  input  logic [PRE_W-1:0] preload_two_i,
  input  logic             flag_clr_i,
  output logic             irq_o,
  output logic             smi_o,
  output logic             rst_req_o,
  output logic             prev_reboot_o,
  output logic             stage_o
);

  logic   en_rise;
  logic   cnt_load;
  logic   cnt_sel_two;
  logic   cnt_clear;
  logic   cnt_dec;
  logic   cnt_last;
  logic   flag_set;
  stage_e stage;

  wdog_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .rise_o (en_rise)
  );

  wdog_count #(
    .PRE_W      (PRE_W),
    .SLOW_SHIFT (SLOW_SHIFT),
    .FAST_SHIFT (FAST_SHIFT)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_one_i (preload_one_i),
    .pre_two_i (preload_two_i),
    .fast_i    (fast_scale_i),
    .load_i    (cnt_load),
    .sel_two_i (cnt_sel_two),
    .clear_i   (cnt_clear),
    .dec_i     (cnt_dec),
    .last_o    (cnt_last)
  );

  wdog_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .rise_i      (en_rise),
    .kick_i      (kick_i),
    .tick_i      (tick_i),
    .last_i      (cnt_last),
    .free_run_i  (free_run_i),
    .reboot_en_i (reboot_en_i),
    .evt_type_i  (evt_type_i),
    .load_o      (cnt_load),
    .sel_two_o   (cnt_sel_two),
    .clear_o     (cnt_clear),
    .dec_o       (cnt_dec),
    .flag_set_o  (flag_set),
    .irq_o       (irq_o),
    .smi_o       (smi_o),
    .rst_req_o   (rst_req_o),
    .stage_o     (stage)
  );

  wdog_sticky u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o (prev_reboot_o)
  );

  assign stage_o = stage;

  // R7: a reset request is always accompanied by the set flag
  a_r7_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> prev_reboot_o);

endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;

  localparam int PW = 3;
  localparam int SS = 2;
  localparam int FS = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b1;
  logic          en_i = 1'b0;
  logic          free_run_i = 1'b0;
  logic          reboot_en_i = 1'b1;
  logic          fast_scale_i = 1'b0;
  logic [1:0]    evt_type_i = 2'd0;
  logic          kick_i = 1'b0;
  logic [PW-1:0] preload_one_i = '0;
  logic [PW-1:0] preload_two_i = '0;
  logic          flag_clr_i = 1'b0;
  logic          irq_o, smi_o, rst_req_o, prev_reboot_o, stage_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_two_stage #(.PRE_W(PW), .SLOW_SHIFT(SS), .FAST_SHIFT(FS)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .en_i          (en_i),
    .free_run_i    (free_run_i),
    .reboot_en_i   (reboot_en_i),
    .fast_scale_i  (fast_scale_i),
    .evt_type_i    (evt_type_i),
    .kick_i        (kick_i),
    .preload_one_i (preload_one_i),
    .preload_two_i (preload_two_i),
    .flag_clr_i    (flag_clr_i),
    .irq_o         (irq_o),
    .smi_o         (smi_o),
    .rst_req_o     (rst_req_o),
    .prev_reboot_o (prev_reboot_o),
    .stage_o       (stage_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Window length in ticks, computed from the requirement (R2)
  function automatic int win_len(input int pre, input int fast);
    int v;
    v = fast ? (pre << FS) : (pre << SS);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int pack_out();
    return {27'd0, irq_o, smi_o, rst_req_o, prev_reboot_o, stage_o};
  endfunction

  task automatic run_case(input int p1, input int p2, input int fs, input int ty,
                          input int reb, input int fr);
    int e1, e2;
    @(negedge clk);
    en_i = 1'b0; kick_i = 1'b0; flag_clr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    preload_one_i = PW'(p1); preload_two_i = PW'(p2);
    fast_scale_i = fs[0]; evt_type_i = 2'(ty);
    reboot_en_i = reb[0]; free_run_i = fr[0];
    en_i = 1'b1;
    @(negedge clk);
    e1 = win_len(p1, fs);
    e2 = win_len(p2, fs);
    for (int j = 1; j <= e1; j++) begin
      @(negedge clk);
      if (j < e1) begin
        chk(stage_o == 1'b0 && !irq_o && !smi_o, "R4 first window running", pack_out(), 0);
      end else begin
        chk(stage_o == 1'b1, "R2 first window length", j, e1);
        chk(irq_o == (ty == 0), "R6 irq by type", irq_o, (ty == 0));
        chk(smi_o == (ty == 2), "R6 smi by type", smi_o, (ty == 2));
      end
    end
    for (int j = 1; j <= e2; j++) begin
      @(negedge clk);
      if (j < e2) begin
        chk(stage_o == 1'b1 && !rst_req_o && !irq_o && !smi_o,
            "R6 second window running", pack_out(), 1);
      end else begin
        chk(rst_req_o == reb[0], "R7 reset request", rst_req_o, reb);
        chk(prev_reboot_o == reb[0], "R7 flag set", prev_reboot_o, reb);
        chk(stage_o == (fr == 0), "R8 stage after second expiry", stage_o, (fr == 0));
      end
    end
    @(negedge clk);
    chk(!rst_req_o, "R9 request is one cycle", rst_req_o, 0);
    chk(prev_reboot_o == reb[0], "R10 flag sticky", prev_reboot_o, reb);
    if (fr == 0) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(stage_o && !irq_o && !smi_o && !rst_req_o, "R8 parked silent", pack_out(), 1);
      end
      kick_i = 1'b1;
      @(negedge clk);
      kick_i = 1'b0;
      chk(stage_o == 1'b0, "R8 keepalive resumes parked core", stage_o, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    chk(pack_out() == 0, "R1 reset state", pack_out(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pack_out() == 0, "R1 state after release", pack_out(), 0);

    // Sweep of preloads, scales, event types and mode bits
    for (int p1 = 0; p1 < 8; p1++)
      for (int fs = 0; fs < 2; fs++)
        for (int ty = 0; ty < 4; ty++)
          run_case(p1, (p1 * 3 + 1) % 8, fs, ty, (p1 + ty) % 2, (ty + fs) % 2);

    // R5: keepalive in the second window restarts the first window
    @(negedge clk);
    en_i = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    preload_one_i = 3'd3; preload_two_i = 3'd5; fast_scale_i = 1'b0;
    evt_type_i = 2'd0; reboot_en_i = 1'b1; free_run_i = 1'b0; en_i = 1'b1;
    @(negedge clk);
    repeat (20) @(negedge clk);
    chk(stage_o == 1'b1, "R5 in second window before keepalive", stage_o, 1);
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
    chk(stage_o == 1'b0, "R5 keepalive forces first window", stage_o, 0);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j == 11) chk(stage_o == 1'b0, "R5 full first window after keepalive", stage_o, 0);
      if (j == 12) chk(stage_o == 1'b1 && irq_o, "R5 first window ends after reload", pack_out(), 0);
    end

    // R5/R4: disabled core ignores keepalive and stops counting
    en_i = 1'b0;
    @(negedge clk);
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
    chk(stage_o == 1'b1, "R5 keepalive ignored while disabled", stage_o, 1);
    first = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (rst_req_o || irq_o || smi_o || !stage_o) first = 1;
    end
    chk(first == 0, "R4 frozen while disabled", first, 0);
    en_i = 1'b1;
    @(negedge clk);
    chk(stage_o == 1'b0, "R4 enable edge restarts first window", stage_o, 0);

    // R3: gated ticks, one tick every third cycle, window of 4 ticks
    en_i = 1'b0;
    @(negedge clk);
    preload_one_i = 3'd2; fast_scale_i = 1'b1; tick_i = 1'b0; en_i = 1'b1;
    @(negedge clk);
    first = 0;
    for (int j = 1; j <= 20; j++) begin
      tick_i = (j % 3 == 0);
      @(negedge clk);
      if (stage_o && first == 0) first = j;
    end
    chk(first == 12, "R3 window counts only tick cycles", first, 12);
    tick_i = 1'b1;

    // R10: set wins over a simultaneous clear, then clear takes effect
    en_i = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk);
    chk(!prev_reboot_o, "R10 clear", prev_reboot_o, 0);
    preload_one_i = 3'd0; preload_two_i = 3'd0; reboot_en_i = 1'b1;
    free_run_i = 1'b0; en_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(stage_o == 1'b1, "R2 zero preload expires on first tick", stage_o, 1);
    @(negedge clk);
    chk(rst_req_o && prev_reboot_o, "R10 set wins over clear", pack_out(), 6);
    @(negedge clk);
    chk(!prev_reboot_o, "R10 clear after set", prev_reboot_o, 0);
    flag_clr_i = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule